// File: doc/BRIEF.md
# ECC Correctable-Error Log Register

This block is a 64-bit diagnostic register beside a second-level cache. When the cache data path finds a single-bit (correctable) ECC error, the register keeps the 7-bit syndromes of the four 32-bit data words, whether the cache or the processor supplied the bad data, and the tag control bits of the last cache location the controller touched. Syndrome generation and correction are done elsewhere. The syndromes, the per-half error strobes and the transaction type come in as inputs. Software reads the register through a simple CSR port and writes 1 to a flag to clear it.

The register has two halves that work on their own. The lower half (words 0 and 2, plus the tag snapshot) and the upper half (words 1 and 3) each run a two-state controller. In H_OPEN the half is free to capture. A qualifying error strobe takes it through the transition "capture" into H_HELD. In H_HELD the logged fields are frozen, and any further error takes the transition "overflow", which sets the missed flag and leaves the state unchanged. Writing 1 to the flag takes the transition "release" back to H_OPEN. If the flag is cleared and a new error arrives in the same cycle, the transition is "recapture": the half stays in H_HELD and takes the new contents.

An error is logged only for three kinds of access: a processor masked write that hits a shared line, the eviction of a victim line, or a system-bus read or exchange that hits a dirty line. If ECC correction is turned off, a qualifying error is reported on the uncorrectable output and nothing is logged.

Top module: `ecc_ce_log`

## Requirements
- R1: After reset, the four flag bits (35, 34, 3, 2) and the tag bits 11:8 read 0. Bits 48:36, 33:32, 16:12, 7:4 and 1:0 always read 0.
- R2: A qualifying error on a half whose flag is clear sets that half's flag on the next cycle and logs its fields. The syndrome input packs word w at syn_in[7w+6:7w]. The upper half puts word 3 at 63:57, word 1 at 56:50 and src_hi at 49, and sets flag bit 35. The lower half puts word 2 at 31:25, word 0 at 24:18 and src_lo at 17, and sets flag bit 3. A source value of 1 means the cache data caused the error.
- R3: txn_type codes are 0 idle, 1 cpu read, 2 cpu full write, 3 cpu masked write, 4 evict, 5 system read, 6 system exchange, 7 system write. An error qualifies only for code 3 with tag_hit and line_shared, for code 4, or for codes 5 and 6 with tag_hit and line_dirty. Every other error is ignored.
- R4: While a half's flag is set, that half's logged fields do not change. The other half keeps capturing on its own.
- R5: A qualifying error on a half whose flag is set and is not being cleared sets that half's missed flag (34 upper, 2 lower).
- R6: Writing 1 to a flag bit clears that bit, and writing 0 has no effect. A set missed flag does not stop a capture.
- R7: If a flag is cleared and a qualifying error for that half arrives in the same cycle, the flag reads 1 afterwards with the new contents, and the missed flag is not set.
- R8: With ecc_corr_en low, a qualifying error sets no flag and no missed flag and logs nothing. uncorr_err goes high on the next cycle for one cycle.
- R9: Bits 11, 10, 9 and 8 take line_valid, line_dirty, line_shared and ctl_parity on every non-idle access while the lower flag is clear (or being cleared). They hold while that flag is set.
- R10: If a missed flag is cleared in the same cycle that a new overflow occurs, the missed flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| txn_type | input | 3 | Current cache transaction code (see R3) |
| tag_hit | input | 1 | Access hit in the tag store |
| line_valid | input | 1 | Valid bit of the accessed line |
| line_dirty | input | 1 | Dirty bit of the accessed line |
| line_shared | input | 1 | Shared bit of the accessed line |
| ctl_parity | input | 1 | Parity of the line's control bits |
| ce_lo | input | 1 | Correctable error seen in words 0/2 |
| ce_hi | input | 1 | Correctable error seen in words 1/3 |
| syn_in | input | 28 | Four 7-bit syndromes, word w at bits 7w+6:7w |
| src_lo | input | 1 | Lower-half error source, 1 means cache data |
| src_hi | input | 1 | Upper-half error source, 1 means cache data |
| ecc_corr_en | input | 1 | ECC correction enabled |
| csr_wr | input | 1 | CSR write strobe |
| csr_wdata | input | 64 | CSR write data, 1 in a flag bit clears it |
| csr_rdata | output | 64 | Current register contents |
| uncorr_err | output | 1 | One-cycle pulse for an error while correction is off |

## Verification
The hardest cases to reach from the ports are the ones where a flag clear meets a new error in the same cycle (recapture, and a missed flag being cleared during an overflow). A half is filled first, then the bench drives csr_wr with the chosen clear bits in the same cycle as a fresh error strobe, using syndromes that differ from the ones already logged. The transaction qualifier is swept over all eight codes and every combination of hit, shared and dirty. A reference model in the bench follows the register every cycle.

// File: rtl/ecc_ce_log_pkg.sv
package ecc_ce_log_pkg;

    typedef enum logic [2:0] {
        TXN_IDLE          = 3'd0,
        TXN_CPU_READ      = 3'd1,
        TXN_CPU_WR_FULL   = 3'd2,
        TXN_CPU_WR_MASKED = 3'd3,
        TXN_EVICT         = 3'd4,
        TXN_SYS_READ      = 3'd5,
        TXN_SYS_XCHG      = 3'd6,
        TXN_SYS_WRITE     = 3'd7
    } txn_t;

    typedef enum logic {
        H_OPEN = 1'b0,
        H_HELD = 1'b1
    } half_state_t;

    localparam int NUM_HALVES  = 2;
    localparam int HALF_OFS    = 32;
    // lower-half bit positions; the upper half sits HALF_OFS above
    localparam int LO_MISS_BIT = 2;
    localparam int LO_FLAG_BIT = 3;
    localparam int TAG_LSB     = 8;
    localparam int LO_SRC_BIT  = 17;
    localparam int LO_SYNB_LSB = 18;
    localparam int LO_SYNA_LSB = 25;

endpackage

// File: rtl/ce_txn_qualify.sv
module ce_txn_qualify
    import ecc_ce_log_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] txn_i,
    input  logic       tag_hit_i,
    input  logic       line_shared_i,
    input  logic       line_dirty_i,
    output logic       access_o,
    output logic       qual_o
);

    txn_t txn;

    always_comb begin
        txn      = txn_t'(txn_i);
        access_o = (txn != TXN_IDLE);
        unique case (txn)
            TXN_CPU_WR_MASKED:          qual_o = tag_hit_i & line_shared_i;
            TXN_EVICT:                  qual_o = 1'b1;
            TXN_SYS_READ, TXN_SYS_XCHG: qual_o = tag_hit_i & line_dirty_i;
            default:                    qual_o = 1'b0;
        endcase
    end

    // R3: an idle slot or a plain read never qualifies
    a_r3_idle_never_qualifies: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_i == TXN_IDLE || txn_i == TXN_CPU_READ) |-> !qual_o);

endmodule

// File: rtl/ce_log_half.sv
module ce_log_half
    import ecc_ce_log_pkg::*;
#(
    parameter int SYN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_i,
    input  logic [SYN_W-1:0] syn_a_i,
    input  logic [SYN_W-1:0] syn_b_i,
    input  logic             src_i,
    input  logic             clr_flag_i,
    input  logic             clr_miss_i,
    output logic             open_o,
    output logic             flag_o,
    output logic             miss_o,
    output logic [SYN_W-1:0] syn_a_o,
    output logic [SYN_W-1:0] syn_b_o,
    output logic             src_o
);

    half_state_t      state_q, state_d;
    logic             capture, miss_set;
    logic             miss_q;
    logic [SYN_W-1:0] syn_a_q, syn_b_q;
    logic             src_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= H_OPEN;
        else        state_q <= state_d;
    end

    // transitions and per-cycle controls
    always_comb begin
        open_o   = (state_q == H_OPEN) || clr_flag_i;
        capture  = err_i && open_o;
        miss_set = err_i && !open_o;
        state_d  = state_q;
        unique case (state_q)
            H_OPEN: if (capture) state_d = H_HELD;                  // capture
            H_HELD: if (clr_flag_i)
                        state_d = capture ? H_HELD : H_OPEN;        // recapture / release
                    else
                        state_d = H_HELD;                           // overflow or idle
            default: state_d = H_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) miss_q <= 1'b0;
        else        miss_q <= (miss_q & ~clr_miss_i) | miss_set;
    end

    // log fields carry no reset value
    always_ff @(posedge clk) begin
        if (capture) begin
            syn_a_q <= syn_a_i;
            syn_b_q <= syn_b_i;
            src_q   <= src_i;
        end
    end

    assign flag_o  = (state_q == H_HELD);
    assign miss_o  = miss_q;
    assign syn_a_o = syn_a_q;
    assign syn_b_o = syn_b_q;
    assign src_o   = src_q;

    // R2: an error on an open half leaves it held
    a_r2_capture_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i && !flag_o) |=> flag_o);

    // R4: held contents stay put until software releases them
    a_r4_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_flag_i) |=> ($stable(syn_a_o) && $stable(syn_b_o) && $stable(src_o)));

    // R5: an error against a held half is remembered as missed
    a_r5_missed_on_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_flag_i && err_i) |=> miss_o);

    // R6: a clear with no new error releases the half
    a_r6_w1c_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flag_i && !err_i) |=> !flag_o);

    // R7: clear plus error ends held with the new syndrome
    a_r7_clear_and_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flag_i && err_i) |=> (flag_o && syn_a_o == $past(syn_a_i) && syn_b_o == $past(syn_b_i)));

    // R10: an overflow beats a same-cycle missed clear
    a_r10_missed_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_miss_i && flag_o && !clr_flag_i && err_i) |=> miss_o);

endmodule

// File: rtl/ce_tag_snap.sv
module ce_tag_snap #(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             access_i,
    input  logic             open_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic [TAG_W-1:0] tag_o
);

    logic [TAG_W-1:0] tag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  tag_q <= '0;
        else if (access_i && open_i) tag_q <= tag_i;
    end

    assign tag_o = tag_q;

    // R9: snapshot frozen while the lower half is held
    a_r9_tag_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_i) |=> $stable(tag_o));

endmodule

// File: rtl/ce_log_pack.sv
module ce_log_pack
    import ecc_ce_log_pkg::*;
#(
    parameter int SYN_W = 7,
    parameter int TAG_W = 4,
    parameter int LOG_W = 64
) (
    input  logic [NUM_HALVES-1:0]       flag_i,
    input  logic [NUM_HALVES-1:0]       miss_i,
    input  logic [NUM_HALVES-1:0]       src_i,
    input  logic [NUM_HALVES*SYN_W-1:0] syn_a_i,
    input  logic [NUM_HALVES*SYN_W-1:0] syn_b_i,
    input  logic [TAG_W-1:0]            tag_i,
    output logic [LOG_W-1:0]            rdata_o
);

    always_comb begin
        rdata_o = '0;
        for (int h = 0; h < NUM_HALVES; h++) begin
            rdata_o[h*HALF_OFS + LO_FLAG_BIT]          = flag_i[h];
            rdata_o[h*HALF_OFS + LO_MISS_BIT]          = miss_i[h];
            rdata_o[h*HALF_OFS + LO_SRC_BIT]           = src_i[h];
            rdata_o[h*HALF_OFS + LO_SYNA_LSB +: SYN_W] = syn_a_i[h*SYN_W +: SYN_W];
            rdata_o[h*HALF_OFS + LO_SYNB_LSB +: SYN_W] = syn_b_i[h*SYN_W +: SYN_W];
        end
        rdata_o[TAG_LSB +: TAG_W] = tag_i;
    end

endmodule

// File: rtl/ecc_ce_log.sv
module ecc_ce_log
    import ecc_ce_log_pkg::*;
#(
    parameter int SYN_W = 7,
    parameter int LOG_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         txn_type,
    input  logic               tag_hit,
    input  logic               line_valid,
    input  logic               line_dirty,
    input  logic               line_shared,
    input  logic               ctl_parity,
    input  logic               ce_lo,
    input  logic               ce_hi,
    input  logic [4*SYN_W-1:0] syn_in,
    input  logic               src_lo,
    input  logic               src_hi,
    input  logic               ecc_corr_en,
    input  logic               csr_wr,
    input  logic [LOG_W-1:0]   csr_wdata,
    output logic [LOG_W-1:0]   csr_rdata,
    output logic               uncorr_err
);

    localparam int TAG_W = 4;

    logic                        access, qual;
    logic [NUM_HALVES-1:0]       ce_vec, src_vec, err_vec;
    logic [NUM_HALVES-1:0]       open_vec, flag_vec, miss_vec, srcq_vec;
    logic [NUM_HALVES*SYN_W-1:0] syn_a_vec, syn_b_vec;
    logic [TAG_W-1:0]            tag_q;
    logic                        uncorr_q;
    logic                        unused_wdata;

    assign unused_wdata = ^{csr_wdata[LOG_W-1:36], csr_wdata[33:4], csr_wdata[1:0]};

    ce_txn_qualify u_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .txn_i        (txn_type),
        .tag_hit_i    (tag_hit),
        .line_shared_i(line_shared),
        .line_dirty_i (line_dirty),
        .access_o     (access),
        .qual_o       (qual)
    );

    assign ce_vec  = {ce_hi, ce_lo};
    assign src_vec = {src_hi, src_lo};
    assign err_vec = ce_vec & {NUM_HALVES{qual & ecc_corr_en}};

    for (genvar gi = 0; gi < NUM_HALVES; gi++) begin : g_half
        ce_log_half #(.SYN_W(SYN_W)) u_half (
            .clk       (clk),
            .rst_n     (rst_n),
            .err_i     (err_vec[gi]),
            .syn_a_i   (syn_in[(gi+2)*SYN_W +: SYN_W]),
            .syn_b_i   (syn_in[gi*SYN_W +: SYN_W]),
            .src_i     (src_vec[gi]),
            .clr_flag_i(csr_wr & csr_wdata[gi*HALF_OFS + LO_FLAG_BIT]),
            .clr_miss_i(csr_wr & csr_wdata[gi*HALF_OFS + LO_MISS_BIT]),
            .open_o    (open_vec[gi]),
            .flag_o    (flag_vec[gi]),
            .miss_o    (miss_vec[gi]),
            .syn_a_o   (syn_a_vec[gi*SYN_W +: SYN_W]),
            .syn_b_o   (syn_b_vec[gi*SYN_W +: SYN_W]),
            .src_o     (srcq_vec[gi])
        );
    end

    ce_tag_snap #(.TAG_W(TAG_W)) u_tag (
        .clk     (clk),
        .rst_n   (rst_n),
        .access_i(access),
        .open_i  (open_vec[0]),
        .tag_i   ({line_valid, line_dirty, line_shared, ctl_parity}),
        .tag_o   (tag_q)
    );

    ce_log_pack #(.SYN_W(SYN_W), .TAG_W(TAG_W), .LOG_W(LOG_W)) u_pack (
        .flag_i (flag_vec),
        .miss_i (miss_vec),
        .src_i  (srcq_vec),
        .syn_a_i(syn_a_vec),
        .syn_b_i(syn_b_vec),
        .tag_i  (tag_q),
        .rdata_o(csr_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) uncorr_q <= 1'b0;
        else        uncorr_q <= (|ce_vec) & qual & ~ecc_corr_en;
    end

    assign uncorr_err = uncorr_q;

    // R8: with correction off, a qualifying error is reported as uncorrectable
    a_r8_uncorr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ((ce_lo || ce_hi) && qual && !ecc_corr_en) |=> uncorr_err);

    // R8: with correction off, a clear lower flag stays clear
    a_r8_no_flag_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ecc_corr_en && !flag_vec[0]) |=> !csr_rdata[LO_FLAG_BIT]);

endmodule

// File: tb/ecc_ce_log_test.sv
module ecc_ce_log_test;

    localparam logic [63:0] HI_FIELDS = 64'hFFFE_0000_0000_0000;
    localparam logic [63:0] LO_FIELDS = 64'h0000_0000_FFFE_0000;
    localparam logic [63:0] ALL_ONES  = '1;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  txn_type;
    logic        tag_hit, line_valid, line_dirty, line_shared, ctl_parity;
    logic        ce_lo, ce_hi, src_lo, src_hi, ecc_corr_en, csr_wr;
    logic [27:0] syn_in;
    logic [63:0] csr_wdata;
    logic [63:0] csr_rdata;
    logic        uncorr_err;

    int          checks = 0;
    int          errors = 0;
    logic [63:0] exp_q, known;
    logic        exp_unc;

    always #5 clk = ~clk;

    ecc_ce_log uut (
        .clk(clk), .rst_n(rst_n), .txn_type(txn_type), .tag_hit(tag_hit),
        .line_valid(line_valid), .line_dirty(line_dirty), .line_shared(line_shared),
        .ctl_parity(ctl_parity), .ce_lo(ce_lo), .ce_hi(ce_hi), .syn_in(syn_in),
        .src_lo(src_lo), .src_hi(src_hi), .ecc_corr_en(ecc_corr_en),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .uncorr_err(uncorr_err)
    );

    function automatic logic qualifies(input logic [2:0] t, input logic h, input logic s, input logic d);
        return (t == 3'd3 && h && s) || (t == 3'd4) || ((t == 3'd5 || t == 3'd6) && h && d);
    endfunction

    task automatic idle_inputs();
        txn_type = 3'd0; tag_hit = 0; line_valid = 0; line_dirty = 0; line_shared = 0;
        ctl_parity = 0; ce_lo = 0; ce_hi = 0; src_lo = 0; src_hi = 0;
        ecc_corr_en = 1; csr_wr = 0; csr_wdata = '0; syn_in = '0;
    endtask

    // apply the model to the inputs now driven, cross one edge, then compare
    task automatic step(input string req);
        logic [63:0] n;
        logic        q, ev_h, ev_l, fle_h, fle_l;
        n     = exp_q;
        q     = qualifies(txn_type, tag_hit, line_shared, line_dirty);
        ev_h  = ce_hi & q & ecc_corr_en;
        ev_l  = ce_lo & q & ecc_corr_en;
        fle_h = exp_q[35] & ~(csr_wr & csr_wdata[35]);
        fle_l = exp_q[3]  & ~(csr_wr & csr_wdata[3]);
        n[34] = (exp_q[34] & ~(csr_wr & csr_wdata[34])) | (ev_h & fle_h);
        n[2]  = (exp_q[2]  & ~(csr_wr & csr_wdata[2]))  | (ev_l & fle_l);
        if (ev_h && !fle_h) begin
            n[35] = 1; n[63:57] = syn_in[27:21]; n[56:50] = syn_in[13:7]; n[49] = src_hi;
            known = known | HI_FIELDS;
        end else n[35] = fle_h;
        if (ev_l && !fle_l) begin
            n[3] = 1; n[31:25] = syn_in[20:14]; n[24:18] = syn_in[6:0]; n[17] = src_lo;
            known = known | LO_FIELDS;
        end else n[3] = fle_l;
        if (txn_type != 3'd0 && !fle_l)
            n[11:8] = {line_valid, line_dirty, line_shared, ctl_parity};
        exp_unc = (ce_hi | ce_lo) & q & ~ecc_corr_en;
        exp_q   = n;
        @(negedge clk);
        checks++;
        if ((csr_rdata & known) !== (exp_q & known) || uncorr_err !== exp_unc) begin
            errors++;
            $display("FAIL %s: rdata=%h uncorr=%b expected rdata=%h uncorr=%b (mask %h)",
                     req, csr_rdata & known, uncorr_err, exp_q & known, exp_unc, known);
        end
    endtask

    task automatic clear_all(input string req);
        idle_inputs();
        csr_wr = 1; csr_wdata = ALL_ONES;
        step(req);
        idle_inputs();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        exp_q = '0; exp_unc = 0;
        known = ~(HI_FIELDS | LO_FIELDS);
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state of flags, tag and reserved bits
        checks++;
        if ((csr_rdata & known) !== 64'd0 || uncorr_err !== 1'b0) begin
            errors++;
            $display("FAIL R1: rdata=%h uncorr=%b expected rdata=%h uncorr=0", csr_rdata & known, uncorr_err, 64'd0);
        end
        step("R1 idle");

        // R3 and R2: sweep every code with hit/shared/dirty, both halves strobed
        for (int t = 0; t < 8; t++)
            for (int c = 0; c < 8; c++) begin
                idle_inputs();
                txn_type = 3'(t); tag_hit = c[0]; line_shared = c[1]; line_dirty = c[2];
                ce_lo = 1; ce_hi = 1;
                syn_in = 28'(t * 1234567 + c * 40961 + 77);
                src_hi = c[0] ^ t[0]; src_lo = ~c[1];
                line_valid = t[1]; ctl_parity = c[2];
                step("R3 qualifier sweep, R2 capture layout");
                clear_all("R6 clear after sweep");
            end

        // R4 and R5: fill lower half, then overflow it while upper captures
        idle_inputs(); txn_type = 3'd4; ce_lo = 1; syn_in = 28'h0A5_C3E1; src_lo = 1;
        step("R2 lower capture");
        for (int k = 0; k < 3; k++) begin
            idle_inputs(); txn_type = 3'd4; ce_lo = 1; syn_in = 28'(k * 99991 + 5);
            step("R5 overflow sets missed, R4 fields held");
        end
        idle_inputs(); txn_type = 3'd5; tag_hit = 1; line_dirty = 1; ce_hi = 1;
        syn_in = 28'h7F0_1234; src_hi = 1;
        step("R4 upper independent of held lower");

        // R6: zero writes do nothing, single-bit clears
        idle_inputs(); csr_wr = 1; csr_wdata = ~(64'h0000_000C_0000_000C);
        step("R6 write zero to flags");
        idle_inputs(); csr_wr = 1; csr_wdata = 64'h4;
        step("R6 clear lower missed only");
        idle_inputs(); txn_type = 3'd3; tag_hit = 1; line_shared = 1; ce_lo = 1; syn_in = 28'h123_4567;
        step("R5 overflow again");
        idle_inputs(); csr_wr = 1; csr_wdata = 64'h8;
        step("R6 clear lower flag, missed kept");
        idle_inputs(); txn_type = 3'd6; tag_hit = 1; line_dirty = 1; ce_lo = 1; syn_in = 28'h0F0_F0F0;
        step("R6 missed does not block capture");

        // R7: clear and new error together, both halves
        idle_inputs(); txn_type = 3'd4; ce_lo = 1; ce_hi = 1; syn_in = 28'h555_AAAA; src_lo = 0; src_hi = 0;
        csr_wr = 1; csr_wdata = 64'h0000_0008_0000_0008;
        step("R7 clear with recapture");

        // R10: missed clear during an overflow
        idle_inputs(); txn_type = 3'd4; ce_lo = 1; ce_hi = 1; syn_in = 28'h1;
        csr_wr = 1; csr_wdata = 64'h0000_0004_0000_0004;
        step("R10 missed set wins");
        idle_inputs(); csr_wr = 1; csr_wdata = 64'h0000_0004_0000_0004;
        step("R10 missed then clears");
        clear_all("R6 clear all");

        // R8: correction off, every code strobed
        for (int t = 0; t < 8; t++) begin
            idle_inputs(); ecc_corr_en = 0; txn_type = 3'(t);
            tag_hit = 1; line_shared = 1; line_dirty = 1; ce_lo = t[0]; ce_hi = ~t[0];
            syn_in = 28'(t * 7777);
            step("R8 correction off");
        end
        idle_inputs();
        step("R8 uncorrectable pulse ends");

        // R9: tag snapshot follows accesses, idle ignored, frozen when held
        for (int k = 0; k < 16; k++) begin
            idle_inputs(); txn_type = 3'(k % 3 + 1);
            {line_valid, line_dirty, line_shared, ctl_parity} = 4'(k);
            step("R9 tag follows access");
            idle_inputs(); {line_valid, line_dirty, line_shared, ctl_parity} = ~4'(k);
            step("R9 idle slot keeps tag");
        end
        idle_inputs(); txn_type = 3'd4; ce_lo = 1; {line_valid, line_dirty, line_shared, ctl_parity} = 4'b1010;
        step("R9 tag taken with capture");
        for (int k = 0; k < 4; k++) begin
            idle_inputs(); txn_type = 3'd1; {line_valid, line_dirty, line_shared, ctl_parity} = 4'(k * 5);
            step("R9 tag frozen while held");
        end
        idle_inputs(); txn_type = 3'd2; {line_valid, line_dirty, line_shared, ctl_parity} = 4'b0111;
        csr_wr = 1; csr_wdata = 64'h8;
        step("R9 tag taken on releasing cycle");
        clear_all("R1 final clear");
        idle_inputs();
        step("R1 all flags clear");

        finish_run();
    end

endmodule